// File: doc/BRIEF.md
# Program ROM Bank Translator

This block maps the 32 KB program window of an 8-bit CPU onto a larger physical program ROM. The window is split into four 8 KB slots. Each slot holds a page number. When a CPU access arrives, the slot is chosen by address bits 14:13. The result is one physical ROM byte address, registered for one cycle.

The slot contents change only when a serial-loaded control register is committed. The bank register commit reloads the slots. A commit of either character-bank register can move the 256 KB region base on large ROMs.

The block is told how many 8 KB pages the ROM holds and its size class: small, 512 KB or 1 MB. It is also told whether a separate character ROM is fitted. These strap inputs are held steady between resets. ROM storage itself lies outside the block.

Top module: `prg_page_xlate`

## Requirements
- R1: While `rst` is high at a clock edge, the slots are loaded with pages 0, 1, HI1 and HI2. For the small class, HI1 and HI2 are `rom_pages`-2 and `rom_pages`-1. For the other classes they are 30 and 31. The region base is cleared to 0.
- R2: At each clock edge out of reset, `rom_addr` is set to the physical page times 8192 plus `cpu_addr[12:0]`. The slot used is the one indexed by `cpu_addr[14:13]`.
- R3: A commit with `commit_idx`=3 while `ctrl_reg[3]`=0 works in 32 KB mode. Let n be twice `bank_reg`. Slots 0 and 1 take n and n+1. Slots 2 and 3 take n+2 and n+3 only for the small class; otherwise they are kept.
- R4: A commit with `commit_idx`=3 while `ctrl_reg[3]`=1 and `ctrl_reg[2]`=1 loads n and n+1 into slots 0 and 1. Slots 2 and 3 are reloaded with HI1 and HI2.
- R5: A commit with `commit_idx`=3 while `ctrl_reg[3]`=1 and `ctrl_reg[2]`=0 behaves by class. For the small class, slots 0 and 1 take pages 0 and 1, and slots 2 and 3 take n and n+1. For the other classes, all slots are unchanged.
- R6: The physical page is computed from the linear page (region base × 32 + slot value modulo 32). It is that linear page modulo `rom_pages`, so banks past the end of the ROM wrap to its start.
- R7: For class 512 KB with `has_chr`=0, a commit with `commit_idx`=1 sets the region base to `sel1_reg[4]`. With `has_chr`=1 the same commit leaves the base unchanged.
- R8: For class 1 MB with `ctrl_reg[4]`=0, a commit with `commit_idx`=1 sets the region base as follows. The base becomes 3 when `sel1_reg[4]`=1, and 0 otherwise.
- R9: Two-step base update (class 1 MB). The qualifying commits are: `commit_idx`=1 with `ctrl_reg[4]`=1, or `commit_idx`=2 with `ctrl_reg[3]`=1. A qualifying commit with no update pending only marks one as pending; the base is unchanged. The next qualifying commit clears the pending mark and loads the base. Base bit 0 comes from `sel1_reg[4]`. Base bit 1 comes from `sel2_reg[4]` when `ctrl_reg[3]`=1, and is 0 otherwise.
- R10: Commits with `commit_idx`=0, and all commits on the small class, leave the region base unchanged. A commit with `commit_idx`≠3 leaves the slots unchanged. Size class codes are 0 for small, 1 for 512 KB and 2 for 1 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit | input | 1 | One-cycle strobe: a control register was committed |
| commit_idx | input | 2 | Index of the committed register (0..3) |
| ctrl_reg | input | 5 | Current value of the configuration register |
| sel1_reg | input | 5 | Current value of the first character bank register |
| sel2_reg | input | 5 | Current value of the second character bank register |
| bank_reg | input | 5 | Current value of the program bank register |
| rom_pages | input | PAGE_W | Number of 8 KB pages in the ROM |
| size_class | input | 2 | ROM size class: 0 small, 1 512 KB, 2 1 MB |
| has_chr | input | 1 | A character ROM is fitted |
| cpu_addr | input | 15 | CPU address within the 32 KB window |
| rom_addr | output | PAGE_W+13 | Registered physical ROM byte address |

## Verification
The bench builds the block with its default PAGE_W of 8. This covers the full 128-page range of a 1 MB ROM, so every region base and the topmost page 127 can be reached.

The bench resets the block under three strap settings:
- A 16-page small ROM, where banks past the end wrap back to page 0.
- A 64-page 512 KB ROM, fitted both with and without a character ROM.
- A 128-page 1 MB ROM, which exercises the immediate base select and both two-step base paths, including whether the high base bit is taken.

// File: rtl/prg_xlate_pkg.sv
package prg_xlate_pkg;
  typedef enum logic [1:0] {
    ROM_SMALL = 2'd0,
    ROM_512K  = 2'd1,
    ROM_1M    = 2'd2
  } rom_class_e;

  localparam int OFS_W    = 13;  // byte offset inside an 8 KB page
  localparam int SLOTS    = 4;
  localparam int REG_W    = 5;
  localparam int REGION_W = 2;
  localparam int SLOT_W   = 5;   // pages per 256 KB region = 2**SLOT_W
endpackage

// File: rtl/prg_slot_bank.sv
module prg_slot_bank
  import prg_xlate_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         upd,
  input  logic                         mode_16k,
  input  logic                         switch_low,
  input  logic [REG_W-1:0]             bank_sel,
  input  logic                         is_small,
  input  logic [PAGE_W-1:0]            rom_pages,
  output logic [SLOTS-1:0][PAGE_W-1:0] slot_q
);
  logic [PAGE_W-1:0] hi1, hi2, n_pg;

  always_comb begin
    if (is_small) begin
      hi1 = rom_pages - PAGE_W'(2);
      hi2 = rom_pages - PAGE_W'(1);
    end else begin
      hi1 = PAGE_W'((1 << SLOT_W) - 2);
      hi2 = PAGE_W'((1 << SLOT_W) - 1);
    end
    n_pg = PAGE_W'({bank_sel, 1'b0});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q[0] <= '0;
      slot_q[1] <= PAGE_W'(1);
      slot_q[2] <= hi1;
      slot_q[3] <= hi2;
    end else if (upd) begin
      if (!mode_16k) begin
        slot_q[0] <= n_pg;
        slot_q[1] <= n_pg + PAGE_W'(1);
        if (is_small) begin
          slot_q[2] <= n_pg + PAGE_W'(2);
          slot_q[3] <= n_pg + PAGE_W'(3);
        end
      end else if (switch_low) begin
        slot_q[0] <= n_pg;
        slot_q[1] <= n_pg + PAGE_W'(1);
        slot_q[2] <= hi1;
        slot_q[3] <= hi2;
      end else if (is_small) begin
        slot_q[0] <= '0;
        slot_q[1] <= PAGE_W'(1);
        slot_q[2] <= n_pg;
        slot_q[3] <= n_pg + PAGE_W'(1);
      end
    end
  end

  assert_hi_restore_R4: assert property (@(posedge clk) disable iff (rst)
    (upd && mode_16k && switch_low) |=>
      (slot_q[2] == $past(hi1) && slot_q[3] == $past(hi2)));

  assert_large_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && mode_16k && !switch_low && !is_small) |=> $stable(slot_q));

  assert_no_upd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(slot_q));
endmodule

// File: rtl/prg_region_ctl.sv
module prg_region_ctl
  import prg_xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic [1:0]          commit_idx,
  input  logic [REG_W-1:0]    ctrl,
  input  logic                sel1_b4,
  input  logic                sel2_b4,
  input  rom_class_e          rclass,
  input  logic                has_chr,
  output logic [REGION_W-1:0] base_q
);
  logic pending_q;
  logic c1, c2, big;

  always_comb begin
    c1  = commit && (commit_idx == 2'd1);
    c2  = commit && (commit_idx == 2'd2);
    big = (rclass == ROM_1M);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      pending_q <= 1'b0;
    end else if (c1) begin
      if (big) begin
        if (ctrl[4]) begin
          if (pending_q) begin
            base_q    <= {ctrl[3] & sel2_b4, sel1_b4};
            pending_q <= 1'b0;
          end else begin
            pending_q <= 1'b1;
          end
        end else begin
          base_q <= sel1_b4 ? REGION_W'(3) : REGION_W'(0);
        end
      end else if (rclass == ROM_512K && !has_chr) begin
        base_q <= {1'b0, sel1_b4};
      end
    end else if (c2 && big && ctrl[3]) begin
      if (pending_q) begin
        base_q    <= {sel2_b4, sel1_b4};
        pending_q <= 1'b0;
      end else begin
        pending_q <= 1'b1;
      end
    end
  end

  assert_first_commit_R9: assert property (@(posedge clk) disable iff (rst)
    (c1 && big && ctrl[4] && !pending_q) |=> (pending_q && $stable(base_q)));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (c2 && big && ctrl[3] && pending_q) |=> !pending_q);

  assert_base_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(c1 || c2) |=> $stable(base_q));

  assert_small_base_R10: assert property (@(posedge clk) disable iff (rst)
    (rclass == ROM_SMALL) |=> $stable(base_q));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_xlate_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [OFS_W+1:0]             cpu_addr,
  input  logic [SLOTS-1:0][PAGE_W-1:0] slot_q,
  input  logic [REGION_W-1:0]          base,
  input  logic [PAGE_W-1:0]            rom_pages,
  output logic [PAGE_W+OFS_W-1:0]      rom_addr
);
  logic [PAGE_W-1:0] sel_pg, lin_pg, phys_pg;

  always_comb begin
    sel_pg  = slot_q[cpu_addr[OFS_W+1:OFS_W]];
    lin_pg  = PAGE_W'({base, sel_pg[SLOT_W-1:0]});
    phys_pg = (rom_pages == '0) ? lin_pg : (lin_pg % rom_pages);
  end

  always_ff @(posedge clk) begin
    if (rst) rom_addr <= '0;
    else     rom_addr <= {phys_pg, cpu_addr[OFS_W-1:0]};
  end

  assert_offset_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rom_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])));

  assert_in_rom_R6: assert property (@(posedge clk) disable iff (rst)
    (rom_pages != '0) |=> (rom_addr[PAGE_W+OFS_W-1:OFS_W] < $past(rom_pages)));
endmodule

// File: rtl/prg_page_xlate.sv
module prg_page_xlate
  import prg_xlate_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit,
  input  logic [1:0]              commit_idx,
  input  logic [4:0]              ctrl_reg,
  input  logic [4:0]              sel1_reg,
  input  logic [4:0]              sel2_reg,
  input  logic [4:0]              bank_reg,
  input  logic [PAGE_W-1:0]       rom_pages,
  input  logic [1:0]              size_class,
  input  logic                    has_chr,
  input  logic [14:0]             cpu_addr,
  output logic [PAGE_W+12:0]      rom_addr
);
  rom_class_e                  rclass;
  logic [SLOTS-1:0][PAGE_W-1:0] slot_q;
  logic [REGION_W-1:0]         base_q;

  assign rclass = rom_class_e'(size_class);

  prg_slot_bank #(.PAGE_W(PAGE_W)) u_slots (
    .clk        (clk),
    .rst        (rst),
    .upd        (commit && (commit_idx == 2'd3)),
    .mode_16k   (ctrl_reg[3]),
    .switch_low (ctrl_reg[2]),
    .bank_sel   (bank_reg),
    .is_small   (rclass == ROM_SMALL),
    .rom_pages  (rom_pages),
    .slot_q     (slot_q)
  );

  prg_region_ctl u_region (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .commit_idx (commit_idx),
    .ctrl       (ctrl_reg),
    .sel1_b4    (sel1_reg[4]),
    .sel2_b4    (sel2_reg[4]),
    .rclass     (rclass),
    .has_chr    (has_chr),
    .base_q     (base_q)
  );

  prg_addr_map #(.PAGE_W(PAGE_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .slot_q    (slot_q),
    .base      (base_q),
    .rom_pages (rom_pages),
    .rom_addr  (rom_addr)
  );
endmodule

// File: tb/prg_page_xlate_bench.sv
module prg_page_xlate_bench;
  localparam int PAGE_W = 8;
  localparam int AW     = PAGE_W + 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          commit = 1'b0;
  logic [1:0]    commit_idx = '0;
  logic [4:0]    ctrl_reg = 5'h0C, sel1_reg = '0, sel2_reg = '0, bank_reg = '0;
  logic [PAGE_W-1:0] rom_pages = 8'd16;
  logic [1:0]    size_class = 2'd0;
  logic          has_chr = 1'b0;
  logic [14:0]   cpu_addr = '0;
  logic [AW-1:0] rom_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prg_page_xlate #(.PAGE_W(PAGE_W)) u_prg_page_xlate (
    .clk(clk), .rst(rst), .commit(commit), .commit_idx(commit_idx),
    .ctrl_reg(ctrl_reg), .sel1_reg(sel1_reg), .sel2_reg(sel2_reg),
    .bank_reg(bank_reg), .rom_pages(rom_pages), .size_class(size_class),
    .has_chr(has_chr), .cpu_addr(cpu_addr), .rom_addr(rom_addr)
  );

  // {ctrl, bank, cpu_addr, expected} on a 16-page small ROM
  localparam logic [45:0] VEC [8] = '{
    {5'h0C, 5'd3, 15'h0123, 21'h0C123},  // R4 slot0 = 6
    {5'h0C, 5'd3, 15'h4010, 21'h1C010},  // R4 slot2 = HI1 = 14
    {5'h08, 5'd2, 15'h6005, 21'h0A005},  // R5 small: slot3 = 5
    {5'h08, 5'd2, 15'h2001, 21'h02001},  // R5 small: slot1 = 1
    {5'h00, 5'd1, 15'h7FFF, 21'h0BFFF},  // R3 slot3 = 5
    {5'h00, 5'd1, 15'h0000, 21'h04000},  // R3 slot0 = 2
    {5'h00, 5'd7, 15'h4000, 21'h00000},  // R6 page 16 wraps to 0
    {5'h00, 5'd7, 15'h6000, 21'h02000}   // R6 page 17 wraps to 1
  };

  task automatic do_reset(input logic [PAGE_W-1:0] pg, input logic [1:0] cls,
                          input logic chr);
    @(negedge clk);
    rst = 1'b1; rom_pages = pg; size_class = cls; has_chr = chr;
    ctrl_reg = 5'h0C; sel1_reg = '0; sel2_reg = '0; bank_reg = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_commit(input logic [1:0] idx);
    @(negedge clk);
    commit = 1'b1; commit_idx = idx;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic check_addr(input logic [14:0] a, input logic [AW-1:0] exp,
                            input string tag);
    @(negedge clk);
    cpu_addr = a;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rom_addr !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rom_addr, exp);
    end
  endtask

  initial begin
    // R1: small ROM reset slots 0,1,14,15
    do_reset(8'd16, 2'd0, 1'b0);
    check_addr(15'h0005, 21'h00005, "R1 small slot0");
    check_addr(15'h4000, 21'h1C000, "R1 small slot2");
    check_addr(15'h7ABC, 21'h1FABC, "R1 small slot3");

    for (int i = 0; i < 8; i++) begin
      ctrl_reg = VEC[i][45:41];
      bank_reg = VEC[i][40:36];
      do_commit(2'd0);
      do_commit(2'd3);
      check_addr(VEC[i][35:21], VEC[i][20:0], $sformatf("R2 table vec %0d", i));
    end

    // R10: commit to another index leaves slots alone
    ctrl_reg = 5'h00; bank_reg = 5'd0;
    do_commit(2'd2);
    check_addr(15'h6000, 21'h02000, "R10 non-bank commit");

    // R1 large class: slot3 = 31
    do_reset(8'd128, 2'd2, 1'b1);
    check_addr(15'h6000, 21'h3E000, "R1 large slot3");
    // R8: base 3
    ctrl_reg = 5'h0C; sel1_reg = 5'h10;
    do_commit(2'd1);
    check_addr(15'h0004, 21'hC0004, "R8 base3 slot0");
    check_addr(15'h6000, 21'hFE000, "R8 base3 slot3");
    // R5 large: 16K-high mode leaves slots
    ctrl_reg = 5'h08; bank_reg = 5'd5;
    do_commit(2'd3);
    check_addr(15'h0000, 21'hC0000, "R5 large unchanged");
    // R9 via index 1, high bit taken
    ctrl_reg = 5'h18; sel1_reg = 5'h00; sel2_reg = 5'h10;
    do_commit(2'd1);
    check_addr(15'h0000, 21'hC0000, "R9 first commit pending");
    do_commit(2'd1);
    check_addr(15'h0000, 21'h80000, "R9 second commit base2");
    // R9 via index 2
    sel1_reg = 5'h10; sel2_reg = 5'h00;
    do_commit(2'd2);
    check_addr(15'h0000, 21'h80000, "R9 idx2 pending");
    do_commit(2'd2);
    check_addr(15'h0000, 21'h40000, "R9 idx2 base1");
    // R9 high bit not taken when ctrl[3]=0
    ctrl_reg = 5'h10; sel1_reg = 5'h00; sel2_reg = 5'h10;
    do_commit(2'd1);
    check_addr(15'h0000, 21'h40000, "R9 no-bit3 pending");
    do_commit(2'd1);
    check_addr(15'h0000, 21'h00000, "R9 no-bit3 base0");

    // R7: 512 KB, no character ROM
    do_reset(8'd64, 2'd1, 1'b0);
    sel1_reg = 5'h10;
    do_commit(2'd1);
    check_addr(15'h0000, 21'h40000, "R7 base1 slot0");
    check_addr(15'h6010, 21'h7E010, "R7 base1 slot3");
    // R7: with character ROM the commit is ignored
    do_reset(8'd64, 2'd1, 1'b1);
    sel1_reg = 5'h10;
    do_commit(2'd1);
    check_addr(15'h0000, 21'h00000, "R7 chr fitted ignored");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule